// File: doc/BRIEF.md
# Speed and Transparent Mode Sequencer

This block keeps track of the operating mode of a host-side 1-Wire timing generator that sits on a printer port. After power-up the device is transparent: its enable and status lines are passed straight through to a downstream peripheral, and no 1-Wire traffic can be started. It also holds the speed bit, which selects standard or overdrive timing. The block watches each decoded host command and the levels of the enable input and the enable output. It drives the mode flags and the gate controls that the line-timing and pass-through logic consume.

A speed-toggle command has both command bits low. Each one inverts the speed bit and starts no bus activity. Four toggles in a row, with no other command between them, switch the mode. Leaving transparent mode also needs the enable line to stay idle (high) for a qualification window of `QUIET_CYC` cycles. Returning to transparent mode takes effect straight after the fourth toggle. A guard switches off the enable pass-through if, while transparent, the enable output is held low for the length of the window. A mode change that becomes due while a time slot is in progress waits until the slot ends.

Top module: `owm_mode_seq`

## Requirements
- R1: While reset is asserted and after it is released, `transparent`=1, `od_mode`=0, `enable_gate_on`=1 and `report_low`=0.
- R2: A command with `cmd_dclk`=0 and `cmd_res`=0 (toggle) inverts `od_mode` one cycle after `cmd_valid`, and it never raises `slot_go`.
- R3: A toggle that clears `od_mode` raises `report_low` from the next cycle until `eni` is seen high. A toggle that sets `od_mode` leaves `report_low` at 0.
- R4: Any command other than a toggle restarts the toggle count, so toggles issued before it do not count toward the four.
- R5: In transparent mode, four consecutive toggles followed by `eni` held high for `QUIET_CYC` cycles clear `transparent`. Fewer toggles, or a shorter idle time, leave it set.
- R6: A command that arrives while the idle window is still running cancels the pending exit. A toggle there counts as the first of a new sequence.
- R7: In normal mode, four consecutive toggles set `transparent` in the cycle after the fourth, with no idle wait.
- R8: `slot_go` pulses for one cycle after a non-toggle command only in normal mode. In transparent mode it stays 0.
- R9: In transparent mode, `eno` held low for `QUIET_CYC` cycles clears `enable_gate_on`. It stays 0, even after `eno` returns high, until normal mode is entered. A shorter low period has no effect.
- R10: While `slot_busy`=1 no mode change takes place. A change that became due is applied once `slot_busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eni | input | 1 | Enable input level, low is active |
| eno | input | 1 | Enable output pin level |
| cmd_valid | input | 1 | One-cycle strobe: a command was latched on the enable falling edge |
| cmd_dclk | input | 1 | Latched data/clock command bit |
| cmd_res | input | 1 | Latched reset command bit |
| slot_busy | input | 1 | A 1-Wire time slot is in progress |
| od_mode | output | 1 | Speed bit, 1 = overdrive |
| transparent | output | 1 | Pass-through mode active |
| enable_gate_on | output | 1 | Enable pass-through gate closed (conducting) |
| slot_go | output | 1 | One-cycle start request for a 1-Wire slot |
| report_low | output | 1 | Drive both status outputs low to report a cleared speed bit |

## Verification
The bench builds the block with `QUIET_CYC`=16. At that value the idle-time qualification and the enable-output guard each complete in a few dozen cycles. The bench can therefore step through full four-toggle sequences, cancel the window part-way, and run guard periods just under and just over the limit. With a realistic 10 ms count none of these would be reachable. The sampling margins around the window edge are three to four cycles, so an off-by-several error in the timer is caught while single-cycle pipeline choices are not.

// File: rtl/owm_mode_pkg.sv
// Shared command decode for the mode sequencer.
// Assumes the two command bits are already latched by the host interface.
package owm_mode_pkg;
    typedef enum logic [1:0] {
        CMD_TOGGLE = 2'b00,
        CMD_WR0    = 2'b01,
        CMD_RESET  = 2'b10,
        CMD_RDWR1  = 2'b11
    } cmd_kind_t;

    function automatic cmd_kind_t decode_cmd(input logic dclk, input logic res);
        return cmd_kind_t'({dclk, res});
    endfunction
endpackage

// File: rtl/owm_level_timer.sv
// Measures how long a single-bit signal has held its current level.
// Assumes the input is synchronous. The run count restarts on every level
// change and saturates at LIMIT; `steady` flags a run of LIMIT cycles.
module owm_level_timer #(
    parameter int LIMIT = 16,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic level_q,
    output logic steady
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] run_q;

    // Track the last level and the length of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= RST_LEVEL;
            run_q   <= '0;
        end else begin
            level_q <= sig;
            if (sig != level_q)
                run_q <= '0;
            else if (run_q != CW'(LIMIT))
                run_q <= run_q + 1'b1;
        end
    end

    // Flag a run that has reached the limit.
    always_comb steady = (run_q == CW'(LIMIT));

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(LIMIT));
    assert_run_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sig != level_q) |=> !steady);
endmodule

// File: rtl/owm_mode_core.sv
// Mode state machine: speed bit, toggle counter, transparent flag, exit
// arming, deferred return to transparent, the enable-gate guard and the
// speed report. Assumes cmd_valid is a one-cycle strobe and that the timer
// inputs come from owm_level_timer instances.
module owm_mode_core
    import owm_mode_pkg::*;
#(
    parameter int SEQ_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eni,
    input  logic cmd_valid,
    input  logic cmd_dclk,
    input  logic cmd_res,
    input  logic slot_busy,
    input  logic eni_level,
    input  logic eni_steady,
    input  logic eno_level,
    input  logic eno_steady,
    output logic od_q,
    output logic trans_q,
    output logic gate_off_q,
    output logic go_q,
    output logic rpt_q
);
    localparam int NW = $clog2(SEQ_LEN + 1);
    logic [NW-1:0] cnt_q;
    logic          leave_pend_q;
    logic          is_toggle, seq_done, quiet_ok, guard_hit;

    // Classify the incoming command and the qualification conditions.
    always_comb begin
        is_toggle = cmd_valid && (decode_cmd(cmd_dclk, cmd_res) == CMD_TOGGLE);
        seq_done  = is_toggle && (cnt_q == NW'(SEQ_LEN - 1));
        quiet_ok  = trans_q && (cnt_q == NW'(SEQ_LEN)) && eni_level && eni_steady;
        guard_hit = trans_q && !eno_level && eno_steady;
    end

    // Speed bit and its low report, held until the enable returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_q  <= 1'b0;
            rpt_q <= 1'b0;
        end else if (is_toggle) begin
            od_q  <= !od_q;
            rpt_q <= od_q;
        end else if (eni) begin
            rpt_q <= 1'b0;
        end
    end

    // Toggle counting, mode switching and deferral while a slot runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            trans_q      <= 1'b1;
            leave_pend_q <= 1'b0;
        end else begin
            if (cmd_valid) begin
                if (!is_toggle || cnt_q == NW'(SEQ_LEN))
                    cnt_q <= is_toggle ? NW'(1) : '0;
                else if (seq_done && !trans_q)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end else if (quiet_ok && !slot_busy) begin
                cnt_q <= '0;
            end
            if (seq_done && !trans_q)
                leave_pend_q <= 1'b1;
            else if (leave_pend_q && !slot_busy)
                leave_pend_q <= 1'b0;
            if (!slot_busy) begin
                if ((seq_done && !trans_q) || leave_pend_q)
                    trans_q <= 1'b1;
                else if (quiet_ok && !cmd_valid)
                    trans_q <= 1'b0;
            end
        end
    end

    // Enable-gate guard: latched off while transparent, cleared in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_off_q <= 1'b0;
        else if (!trans_q)
            gate_off_q <= 1'b0;
        else if (guard_hit)
            gate_off_q <= 1'b1;
    end

    // Slot start request, only for real slots in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go_q <= 1'b0;
        else
            go_q <= cmd_valid && !is_toggle && !trans_q && !leave_pend_q;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> trans_q && !od_q && !gate_off_q && !rpt_q);
    assert_toggle_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_toggle |=> od_q != $past(od_q));
    assert_other_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !is_toggle) |=> cnt_q == '0);
    assert_exit_needs_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_q && !cmd_valid && !quiet_ok) |=> trans_q);
    assert_no_go_transparent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> !$past(trans_q));
    assert_busy_holds_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_busy |=> $stable(trans_q));
endmodule

// File: rtl/owm_mode_seq.sv
// Top of the mode sequencer: two level timers (enable idle time and the
// enable-output guard) feeding the mode core. Assumes all inputs are
// synchronous to clk; QUIET_CYC is the 10 ms window in clock cycles.
module owm_mode_seq #(
    parameter int QUIET_CYC = 1250000,
    parameter int SEQ_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eni,
    input  logic eno,
    input  logic cmd_valid,
    input  logic cmd_dclk,
    input  logic cmd_res,
    input  logic slot_busy,
    output logic od_mode,
    output logic transparent,
    output logic enable_gate_on,
    output logic slot_go,
    output logic report_low
);
    logic eni_lvl, eni_std, eno_lvl, eno_std, gate_off;

    owm_level_timer #(.LIMIT(QUIET_CYC), .RST_LEVEL(1'b1)) u_eni_tmr (
        .clk(clk), .rst_n(rst_n), .sig(eni), .level_q(eni_lvl), .steady(eni_std));

    owm_level_timer #(.LIMIT(QUIET_CYC), .RST_LEVEL(1'b1)) u_eno_tmr (
        .clk(clk), .rst_n(rst_n), .sig(eno), .level_q(eno_lvl), .steady(eno_std));

    owm_mode_core #(.SEQ_LEN(SEQ_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .eni(eni), .cmd_valid(cmd_valid),
        .cmd_dclk(cmd_dclk), .cmd_res(cmd_res), .slot_busy(slot_busy),
        .eni_level(eni_lvl), .eni_steady(eni_std),
        .eno_level(eno_lvl), .eno_steady(eno_std),
        .od_q(od_mode), .trans_q(transparent), .gate_off_q(gate_off),
        .go_q(slot_go), .rpt_q(report_low));

    // Gate control is the inverse of the latched guard.
    always_comb enable_gate_on = !gate_off;

    assert_gate_only_transparent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_gate_on && !slot_busy) |-> transparent || $past(transparent));
endmodule

// File: tb/sim_owm_mode_seq.sv
module sim_owm_mode_seq;
    localparam int Q = 16;
    logic clk = 1'b0, rst_n = 1'b0;
    logic eni = 1'b1, eno = 1'b1, cmd_valid = 1'b0, cmd_dclk = 1'b1, cmd_res = 1'b1;
    logic slot_busy = 1'b0;
    logic od_mode, transparent, enable_gate_on, slot_go, report_low;
    int errors = 0, checks = 0;
    logic last_go, last_rpt;

    always #4 clk = !clk;

    owm_mode_seq #(.QUIET_CYC(Q)) u0 (
        .clk(clk), .rst_n(rst_n), .eni(eni), .eno(eno), .cmd_valid(cmd_valid),
        .cmd_dclk(cmd_dclk), .cmd_res(cmd_res), .slot_busy(slot_busy),
        .od_mode(od_mode), .transparent(transparent), .enable_gate_on(enable_gate_on),
        .slot_go(slot_go), .report_low(report_low));

    // ops: 0 toggle, 1 read/write-1 command, 2 long idle on enable
    localparam logic [3:0] VEC [17] = '{
        {2'd0,1'b1,1'b1}, {2'd0,1'b1,1'b0}, {2'd1,1'b1,1'b0},
        {2'd0,1'b1,1'b1}, {2'd0,1'b1,1'b0}, {2'd0,1'b1,1'b1},
        {2'd2,1'b1,1'b1}, {2'd0,1'b1,1'b0}, {2'd0,1'b1,1'b1},
        {2'd2,1'b1,1'b1}, {2'd0,1'b1,1'b0}, {2'd0,1'b1,1'b1},
        {2'd0,1'b1,1'b0}, {2'd2,1'b0,1'b0}, {2'd1,1'b0,1'b0},
        {2'd0,1'b0,1'b1}, {2'd0,1'b0,1'b0}};

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic issue(input logic d, input logic r);
        @(negedge clk); eni = 1'b0; cmd_valid = 1'b1; cmd_dclk = d; cmd_res = r;
        @(negedge clk); last_go = slot_go; cmd_valid = 1'b0;
        @(negedge clk); last_rpt = report_low; eni = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 transparent", transparent, 1'b1);
        chk("R1 od", od_mode, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate", enable_gate_on, 1'b1);
        chk("R1 report", report_low, 1'b0);
        // R4 R5 R6 R7: table walk
        for (int i = 0; i < 17; i++) begin
            case (VEC[i][3:2])
                2'd0: issue(1'b0, 1'b0);
                2'd1: issue(1'b1, 1'b1);
                default: idle(Q + 6);
            endcase
            chk($sformatf("R5 step %0d transparent", i), transparent, VEC[i][1]);
            chk($sformatf("R2 step %0d od", i), od_mode, VEC[i][0]);
        end
        // R5 window edge: reset, four toggles, check just before and after
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        repeat (4) issue(1'b0, 1'b0);
        idle(Q - 5);
        chk("R5 not yet", transparent, 1'b1);
        idle(8);
        chk("R5 entered", transparent, 1'b0);
        // R8 slot start in normal mode
        issue(1'b1, 1'b0);
        chk("R8 go normal", last_go, 1'b1);
        chk("R8 go one cycle", slot_go, 1'b0);
        // R2 R3 toggle sets od: no report, no go
        issue(1'b0, 1'b0);
        chk("R2 no go", last_go, 1'b0);
        chk("R3 set no report", last_rpt, 1'b0);
        issue(1'b0, 1'b0);
        chk("R3 clear reports", last_rpt, 1'b1);
        chk("R3 released", report_low, 1'b0);
        // R10 deferral: restart count with a read, then four toggles while busy
        issue(1'b1, 1'b1);
        slot_busy = 1'b1;
        repeat (4) issue(1'b0, 1'b0);
        chk("R10 held", transparent, 1'b0);
        slot_busy = 1'b0; idle(2);
        chk("R10 applied", transparent, 1'b1);
        // R8 transparent: no start
        issue(1'b1, 1'b1);
        chk("R8 no go transparent", last_go, 1'b0);
        // R9 guard
        eno = 1'b0; idle(Q - 4); eno = 1'b1; idle(2);
        chk("R9 short low", enable_gate_on, 1'b1);
        eno = 1'b0; idle(Q + 4); eno = 1'b1; idle(2);
        chk("R9 long low", enable_gate_on, 1'b0);
        idle(Q + 4);
        chk("R9 latched", enable_gate_on, 1'b0);
        repeat (4) issue(1'b0, 1'b0);
        idle(Q + 6);
        chk("R9 cleared normal", enable_gate_on, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule